// File: doc/BRIEF.md
# Cacheable Read Line-Fill Qualifier

This block sits on the bus side of a processor core. It watches each bus cycle from its start strobe to its last ready and decides two things. The first is whether a cacheable, unlocked read grows into a four-transfer cache line fill. The second is whether the line gathered by that fill may be written into the on-chip cache. Both decisions come from the active-low cache-enable input, sampled at two separate points in the fill.

The cache-enable level is registered on every clock. When a transfer completes on either ready input, the registered value from the clock before it is the one used. If it is low at the first transfer of an eligible read, the cycle becomes a fill and the beat counter starts stepping through four 32-bit transfers. If it is low again before the fourth ready, a one-clock commit pulse follows. An 8-byte paired read, such as a descriptor fetch, takes two transfers and is never converted.

The active-low pseudo-lock output marks transactions that span several bus cycles. It stays low until the last bus cycle of the transaction is current. Write-back mode holds it high. The bus is 32 bits wide, and address generation and the cache arrays lie outside this block.

Top module: `lf_qual`

## Requirements
- R1: After reset, fill_flag=0, xfer_cnt=0, commit_line=0 and plock_n=1.
- R2: A started read with cyc_cacheable=1, cyc_locked=0 and cyc_pair=0 becomes a line fill when a transfer completes and cen_n was 0 on the clock edge before it. Either rdy_n=0 or brdy_n=0 completes the transfer. After that edge, fill_flag=1 and xfer_cnt=1.
- R3: If cen_n was 1 on the clock before the first completing transfer, the cycle ends after that single transfer. fill_flag stays 0 and no commit pulse follows.
- R4: A cycle started with cyc_locked=1 is never converted into a fill, even with cen_n low.
- R5: xfer_cnt advances by one only on an edge where the block is busy and rdy_n=0 or brdy_n=0. Wait clocks hold it. Ready inputs are ignored while idle.
- R6: On the edge of the fourth transfer of a fill, commit_line becomes 1 for exactly one clock if cen_n was 0 on the clock edge before it. Otherwise commit_line stays 0.
- R7: A fill always ends after its fourth transfer, whatever the commit outcome. fill_flag returns to 0 and xfer_cnt returns to 0.
- R8: A paired read (cyc_pair=1) takes exactly two transfers and is never converted. With wb_mode=0, plock_n is 0 from the start of the pair until the first transfer completes.
- R9: With wb_mode=0, plock_n is 0 during a fill while xfer_cnt is 1 or 2, and 1 once xfer_cnt is 3.
- R10: With wb_mode=1, plock_n is 1 at all times.
- R11: cyc_start is ignored while a cycle is in progress. The counter and fill flag are not disturbed.
- R12: A write cycle (cyc_read=0) is never converted into a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | Start strobe of a bus cycle, taken only while idle |
| cyc_read | input | 1 | Cycle is a read |
| cyc_cacheable | input | 1 | Core considers the cycle cacheable |
| cyc_locked | input | 1 | Cycle is a locked cycle |
| cyc_pair | input | 1 | Cycle is an 8-byte two-transfer read |
| wb_mode | input | 1 | 1 = write-back mode, 0 = write-through mode |
| cen_n | input | 1 | Cache enable, active low |
| rdy_n | input | 1 | Non-burst ready, active low |
| brdy_n | input | 1 | Burst ready, active low |
| fill_flag | output | 1 | Cycle has been converted into a line fill |
| xfer_cnt | output | 2 | Index of the current transfer within the cycle |
| commit_line | output | 1 | One-clock pulse: filled line may be written to the cache |
| plock_n | output | 1 | Pseudo-lock, active low |

## Verification
The bench moves cache-enable around each ready. A design that samples it on the ready clock itself, instead of the clock before, converts fills it should refuse, or commits lines it should drop. Separate runs complete the first transfer with burst-ready and with plain ready, start locked, write and paired cycles with cache-enable low, and raise a start strobe in the middle of a fill. A qualifier that ignores the lock or the direction would start spurious fills. One that restarts on a stray strobe would reset its counter. Pseudo-lock is followed through every beat in both modes, which catches an off-by-one release point and a missing write-back override.

// File: rtl/lf_qual_pkg.sv
package lf_qual_pkg;
    typedef enum logic {
        LF_IDLE = 1'b0,
        LF_BUSY = 1'b1
    } lf_state_e;
endpackage

// File: rtl/lf_cen_sample.sv
module lf_cen_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic cen_n,
    output logic cen_low_prev
);
    logic cen_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cen_n_q <= 1'b1;
        else        cen_n_q <= cen_n;
    end

    assign cen_low_prev = !cen_n_q;
endmodule

// File: rtl/lf_plock_gen.sv
module lf_plock_gen #(
    parameter int CNT_W = 2
) (
    input  logic             busy,
    input  logic             multi,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] last_idx,
    input  logic             wb_mode,
    output logic             plock_n
);
    logic hold_lock;

    always_comb begin
        hold_lock = busy && multi && (cnt != last_idx);
        plock_n   = wb_mode || !hold_lock;
    end
endmodule

// File: rtl/lf_qual.sv
module lf_qual
    import lf_qual_pkg::*;
#(
    parameter int FILL_BEATS = 4,
    parameter int PAIR_BEATS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic       cyc_read,
    input  logic       cyc_cacheable,
    input  logic       cyc_locked,
    input  logic       cyc_pair,
    input  logic       wb_mode,
    input  logic       cen_n,
    input  logic       rdy_n,
    input  logic       brdy_n,
    output logic       fill_flag,
    output logic [1:0] xfer_cnt,
    output logic       commit_line,
    output logic       plock_n
);
    localparam int CNT_W = $clog2(FILL_BEATS);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(FILL_BEATS - 1);
    localparam logic [CNT_W-1:0] PAIR_LAST = CNT_W'(PAIR_BEATS - 1);

    typedef struct packed {
        lf_state_e        st;
        logic             fill;
        logic             pair;
        logic             elig;
        logic [CNT_W-1:0] cnt;
        logic             commit;
    } lf_reg_t;

    lf_reg_t r_d, r_q;
    logic    cen_low_prev;
    logic    xfer_done;

    lf_cen_sample u_cen (
        .clk          (clk),
        .rst_n        (rst_n),
        .cen_n        (cen_n),
        .cen_low_prev (cen_low_prev)
    );

    always_comb begin
        xfer_done  = !rdy_n || !brdy_n;
        r_d        = r_q;
        r_d.commit = 1'b0;
        case (r_q.st)
            LF_IDLE: begin
                if (cyc_start) begin
                    r_d.st   = LF_BUSY;
                    r_d.cnt  = '0;
                    r_d.fill = 1'b0;
                    r_d.pair = cyc_pair;
                    r_d.elig = cyc_read && cyc_cacheable && !cyc_locked && !cyc_pair;
                end
            end
            default: begin
                if (xfer_done) begin
                    if (r_q.fill) begin
                        if (r_q.cnt == FILL_LAST) begin
                            r_d.commit = cen_low_prev;
                            r_d.st     = LF_IDLE;
                            r_d.fill   = 1'b0;
                            r_d.cnt    = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end else if (r_q.cnt == '0 && r_q.elig && cen_low_prev) begin
                        r_d.fill = 1'b1;
                        r_d.cnt  = CNT_W'(1);
                    end else if (r_q.pair && r_q.cnt != PAIR_LAST) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else begin
                        r_d.st   = LF_IDLE;
                        r_d.cnt  = '0;
                        r_d.pair = 1'b0;
                        r_d.elig = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: LF_IDLE, fill: 1'b0, pair: 1'b0, elig: 1'b0, cnt: '0, commit: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    lf_plock_gen #(.CNT_W(CNT_W)) u_plock (
        .busy     (r_q.st == LF_BUSY),
        .multi    (r_q.pair || r_q.fill),
        .cnt      (r_q.cnt),
        .last_idx (r_q.fill ? FILL_LAST : PAIR_LAST),
        .wb_mode  (wb_mode),
        .plock_n  (plock_n)
    );

    assign fill_flag   = r_q.fill;
    assign xfer_cnt    = 2'(r_q.cnt);
    assign commit_line = r_q.commit;
endmodule

// File: rtl/lf_qual_chk.sv
module lf_qual_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wb_mode,
    input logic       rdy_n,
    input logic       brdy_n,
    input logic       fill_flag,
    input logic [1:0] xfer_cnt,
    input logic       commit_line,
    input logic       plock_n
);
    AST_COMMIT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_line |=> !commit_line); // R6

    AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        commit_line |-> ($past(fill_flag) && $past(xfer_cnt) == 2'd3)); // R6

    AST_FILL_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        commit_line |-> (!fill_flag && xfer_cnt == 2'd0)); // R7

    AST_CNT_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_flag && rdy_n && brdy_n) |=> ($stable(xfer_cnt) && fill_flag)); // R5

    AST_FILL_ENTRY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_flag) |-> (xfer_cnt == 2'd1)); // R2

    AST_WB_PLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wb_mode |-> plock_n); // R10
endmodule

bind lf_qual lf_qual_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_mode     (wb_mode),
    .rdy_n       (rdy_n),
    .brdy_n      (brdy_n),
    .fill_flag   (fill_flag),
    .xfer_cnt    (xfer_cnt),
    .commit_line (commit_line),
    .plock_n     (plock_n)
);

// File: tb/lf_qual_bench.sv
`timescale 1ns/1ps
module lf_qual_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0, cyc_read = 1'b0, cyc_cacheable = 1'b0;
    logic       cyc_locked = 1'b0, cyc_pair = 1'b0, wb_mode = 1'b0;
    logic       cen_n = 1'b1, rdy_n = 1'b1, brdy_n = 1'b1;
    logic       fill_flag, commit_line, plock_n;
    logic [1:0] xfer_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    bit m_busy, m_fill, m_pair, m_elig, m_commit;
    int m_beat;
    bit m_prev_cen = 1'b1;

    always #10 clk = ~clk;

    lf_qual u_lf_qual (
        .clk (clk), .rst_n (rst_n), .cyc_start (cyc_start), .cyc_read (cyc_read),
        .cyc_cacheable (cyc_cacheable), .cyc_locked (cyc_locked), .cyc_pair (cyc_pair),
        .wb_mode (wb_mode), .cen_n (cen_n), .rdy_n (rdy_n), .brdy_n (brdy_n),
        .fill_flag (fill_flag), .xfer_cnt (xfer_cnt), .commit_line (commit_line),
        .plock_n (plock_n)
    );

    task automatic chk(input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_fill = 0; m_pair = 0; m_elig = 0; m_commit = 0;
            m_beat = 0; m_prev_cen = 1;
        end else begin
            m_commit = 0;
            if (!m_busy) begin
                if (cyc_start) begin
                    m_busy = 1; m_beat = 0; m_fill = 0; m_pair = cyc_pair;
                    m_elig = cyc_read && cyc_cacheable && !cyc_locked && !cyc_pair;
                end
            end else if (!rdy_n || !brdy_n) begin
                if (m_fill) begin
                    if (m_beat == 3) begin
                        m_commit = !m_prev_cen; m_busy = 0; m_fill = 0; m_beat = 0;
                    end else m_beat++;
                end else if (m_beat == 0 && m_elig && !m_prev_cen) begin
                    m_fill = 1; m_beat = 1;
                end else if (m_pair && m_beat == 0) begin
                    m_beat = 1;
                end else begin
                    m_busy = 0; m_beat = 0; m_pair = 0;
                end
            end
            m_prev_cen = cen_n;
        end
    end

    always begin
        @(posedge clk);
        #5;
        if (rst_n && !finished) begin
            chk(fill_flag, m_fill, "R2 fill_flag vs model");
            chk(xfer_cnt, m_beat, "R5 xfer_cnt vs model");
            chk(commit_line, m_commit, "R6 commit_line vs model");
            chk(plock_n, (wb_mode || !(m_busy && (m_pair || m_fill) &&
                          m_beat != (m_fill ? 3 : 1))) ? 1 : 0, "R9 plock_n vs model");
        end
    end

    task automatic go(input bit rd, input bit ca, input bit lk, input bit pr, input bit cen);
        @(negedge clk);
        cyc_start = 1; cyc_read = rd; cyc_cacheable = ca; cyc_locked = lk; cyc_pair = pr;
        cen_n = cen; rdy_n = 1; brdy_n = 1;
        @(posedge clk); #5;
    endtask

    task automatic beat(input bit cen, input bit r, input bit b);
        @(negedge clk);
        cyc_start = 0; cen_n = cen; rdy_n = r; brdy_n = b;
        @(posedge clk); #5;
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk(fill_flag, 0, "R1 reset fill_flag");
        chk(xfer_cnt, 0, "R1 reset xfer_cnt");
        chk(commit_line, 0, "R1 reset commit_line");
        chk(plock_n, 1, "R1 reset plock_n");
        @(negedge clk); rst_n = 1;

        // full fill with commit, write-through
        go(1, 1, 0, 0, 0);
        chk(plock_n, 1, "R9 plock high before conversion");
        beat(0, 0, 1);
        chk(fill_flag, 1, "R2 converted on rdy");
        chk(xfer_cnt, 1, "R2 first beat done");
        chk(plock_n, 0, "R9 plock low beat1");
        beat(0, 1, 1);
        chk(xfer_cnt, 1, "R5 wait holds count");
        beat(0, 1, 0);
        chk(xfer_cnt, 2, "R5 brdy advances");
        beat(0, 1, 0);
        chk(xfer_cnt, 3, "R5 third beat");
        chk(plock_n, 1, "R9 plock released at last beat");
        beat(1, 1, 0);
        chk(commit_line, 1, "R6 commit after last");
        chk(fill_flag, 0, "R7 fill ends");
        beat(1, 1, 1);
        chk(commit_line, 0, "R6 commit one clock");

        // fill refused at last beat, converted by brdy
        go(1, 1, 0, 0, 0);
        beat(0, 1, 0);
        chk(fill_flag, 1, "R2 converted on brdy");
        beat(0, 1, 0);
        beat(1, 1, 0);
        beat(0, 1, 0);
        chk(commit_line, 0, "R6 no commit when cen high");
        chk(fill_flag, 0, "R7 fill ends without commit");
        chk(xfer_cnt, 0, "R7 count cleared");

        // cen high at first transfer
        go(1, 1, 0, 0, 1);
        beat(0, 0, 1);
        chk(fill_flag, 0, "R3 not converted");
        beat(0, 0, 1);
        chk(xfer_cnt, 0, "R5 ready ignored idle");
        chk(commit_line, 0, "R3 no commit");

        // locked read
        go(1, 1, 1, 0, 0);
        beat(0, 0, 1);
        chk(fill_flag, 0, "R4 locked not converted");
        beat(0, 0, 1);
        chk(xfer_cnt, 0, "R4 locked ends single");

        // write cycle
        go(0, 1, 0, 0, 0);
        beat(0, 1, 0);
        chk(fill_flag, 0, "R12 write not converted");

        // paired read, write-through
        go(1, 1, 0, 1, 0);
        chk(plock_n, 0, "R8 plock low at pair start");
        beat(0, 0, 1);
        chk(xfer_cnt, 1, "R8 pair second beat");
        chk(fill_flag, 0, "R8 pair not converted");
        chk(plock_n, 1, "R8 plock released");
        beat(0, 0, 1);
        chk(xfer_cnt, 0, "R8 pair done");

        // start strobe during a fill
        go(1, 1, 0, 0, 0);
        beat(0, 0, 1);
        beat(0, 0, 1);
        @(negedge clk);
        cyc_start = 1; cyc_locked = 1; cyc_read = 0; rdy_n = 1; brdy_n = 1;
        @(posedge clk); #5;
        chk(xfer_cnt, 2, "R11 count kept");
        chk(fill_flag, 1, "R11 fill kept");
        beat(0, 0, 1);
        beat(0, 0, 1);
        chk(commit_line, 1, "R11 fill completes");

        // write-back mode
        @(negedge clk); wb_mode = 1;
        go(1, 1, 0, 0, 0);
        beat(0, 0, 1);
        chk(fill_flag, 1, "R10 fill in wb");
        chk(plock_n, 1, "R10 plock forced high");
        beat(0, 0, 1);
        beat(0, 0, 1);
        beat(0, 0, 1);
        chk(commit_line, 1, "R10 commit in wb");
        go(1, 1, 0, 1, 0);
        chk(plock_n, 1, "R10 pair plock high in wb");
        beat(0, 0, 1);
        beat(0, 0, 1);
        beat(1, 1, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule